// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations for a processor pipeline. A lookup presents a 20-bit virtual page number, the 12-bit page offset, the access kind and the privilege mode. In the same cycle it answers with a hit and a 34-bit physical address, or with a miss. On a miss, an external page-table walker fetches the mapping and writes it back through the refill port. Every stored entry can match any page number, so the cache is fully associative.

A hit is also checked against the entry's read, write, execute and user permission bits. A failed check raises a protection fault next to the hit. A store that lands on a page whose dirty bit is still clear is reported as a miss, so that the walker can set the dirty bit. On a context switch the flush input drops every stored translation in a single edge.

Top module: `xlat_tlb`

## Requirements
- R1: When `lk_req` is high and a valid entry holds `lk_vpn`, and R3 does not apply, `lk_hit` is 1 in the same cycle and `lk_paddr` equals the entry's physical page number concatenated above `lk_ofs`.
- R2: When `lk_req` is high and no valid entry holds `lk_vpn`, `lk_miss` is 1 and `lk_hit`, `lk_fault` and `lk_paddr` are 0. When `lk_req` is low, `lk_hit`, `lk_miss`, `lk_fault` and `lk_paddr` are all 0.
- R3: A store (`lk_kind` = 01) that matches an entry whose dirty bit (fill_perm bit 4) is 0 gives `lk_miss`=1 and `lk_hit`=0, whatever the other permission bits are.
- R4: On a hit, `lk_fault` is 1 unless two conditions both hold. The first is that the access kind is allowed: kind 00 (load) needs R (bit 0), kind 01 (store) needs W (bit 1), kind 10 (fetch) needs X (bit 2), and kind 11 is never allowed. The second is that the mode matches: `lk_user`=1 needs U (bit 3) = 1, and `lk_user`=0 needs U = 0.
- R5: A refill picks its slot in this order. It overwrites the entry that already holds the same page number. Failing that, it fills the lowest-numbered invalid entry. If every entry is valid, it replaces the entry at a replacement pointer, and the pointer then advances by one, wrapping from the last entry to 0. In the first two cases the pointer does not move.
- R6: A cycle with `flush` high invalidates every entry at that clock edge and sets the replacement pointer to 0. Every lookup after that edge misses until a new refill.
- R7: If `flush` and `fill_en` are both high in the same cycle, the refill is discarded and the cache is left empty.
- R8: After reset, every entry is invalid and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries (context switch) |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_ofs | input | 12 | Page offset, passed through |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_hit | output | 1 | Usable translation found |
| lk_miss | output | 1 | Walker refill needed |
| lk_fault | output | 1 | Protection violation on the hit |
| lk_paddr | output | 34 | Physical address on hit, else 0 |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 22 | Refill physical page number |
| fill_perm | input | 5 | {D,U,X,W,R} permission and dirty bits |

## Verification
The bench builds the cache with four entries. It rewrites a single page with all 32 combinations of the permission bits and, for each one, looks it up with every access kind and both privilege modes. This sweep separates a clean hit, a dirty-bit miss and a protection fault, and the expected outcome of each combination is worked out arithmetically in the bench.

The eviction order is tested on a cache that is full after repeated rewrites of one page. Each lookup after an eviction shows whether a duplicate entry was created and whether the replacement pointer advanced and wrapped. The same eviction test, repeated after a flush, shows whether the flush returned the pointer to 0. A flush issued together with a refill shows that the flush takes priority.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam logic [1:0] KIND_LOAD  = 2'b00;
  localparam logic [1:0] KIND_STORE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  typedef struct packed {
    logic d;
    logic u;
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic kind_allowed(perm_t p, logic [1:0] kind);
    case (kind)
      KIND_LOAD:  return p.r;
      KIND_STORE: return p.w;
      KIND_FETCH: return p.x;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic mode_allowed(perm_t p, logic user);
    return user ? p.u : ~p.u;
  endfunction

  function automatic logic access_ok(perm_t p, logic [1:0] kind, logic user);
    return kind_allowed(p, kind) & mode_allowed(p, user);
  endfunction

  function automatic logic needs_dirty_walk(perm_t p, logic [1:0] kind);
    return (kind == KIND_STORE) & ~p.d;
  endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N  = 32,
  parameter int VW = 20,
  parameter int IW = 5
) (
  input  logic [N-1:0]  vld,
  input  logic [VW-1:0] tags [N],
  input  logic [VW-1:0] key,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld[g] & (tags[g] == key);
    end
  endgenerate

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  vld,
  input  logic [IW-1:0] ptr,
  input  logic          same_any,
  input  logic [IW-1:0] same_idx,
  output logic [IW-1:0] slot,
  output logic          advance
);
  logic          free_any;
  logic [IW-1:0] free_idx;

  assign free_any = ~&vld;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = i[IW-1:0];
    end
  end

  always_comb begin
    advance = 1'b0;
    if (same_any)      slot = same_idx;
    else if (free_any) slot = free_idx;
    else begin
      slot    = ptr;
      advance = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 22,
  parameter int OFS_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lk_req,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFS_W-1:0]       lk_ofs,
  input  logic [1:0]             lk_kind,
  input  logic                   lk_user,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [4:0]             fill_perm
);
  import xlat_pkg::*;

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [IW-1:0]      ptr_q;

  // lookup path
  logic          lk_any;
  logic [IW-1:0] lk_idx;
  perm_t         lk_perm;
  logic          lk_raw;
  logic          lk_dirty_walk;

  xlat_cam #(.N(ENTRIES), .VW(VPN_W), .IW(IW)) u_lk_cam (
    .vld(valid_q), .tags(tag_q), .key(lk_vpn), .any(lk_any), .idx(lk_idx)
  );

  assign lk_perm       = perm_q[lk_idx];
  assign lk_raw        = lk_req & lk_any;
  assign lk_dirty_walk = lk_raw & needs_dirty_walk(lk_perm, lk_kind);
  assign lk_hit        = lk_raw & ~lk_dirty_walk;
  assign lk_miss       = lk_req & ~lk_hit;
  assign lk_fault      = lk_hit & ~access_ok(lk_perm, lk_kind, lk_user);
  assign lk_paddr      = lk_hit ? {ppn_q[lk_idx], lk_ofs} : '0;

  // refill path
  logic          fill_same_any;
  logic [IW-1:0] fill_same_idx;
  logic [IW-1:0] fill_slot;
  logic          fill_adv;
  logic          fill_we;

  xlat_cam #(.N(ENTRIES), .VW(VPN_W), .IW(IW)) u_fill_cam (
    .vld(valid_q), .tags(tag_q), .key(fill_vpn),
    .any(fill_same_any), .idx(fill_same_idx)
  );

  xlat_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .vld(valid_q), .ptr(ptr_q), .same_any(fill_same_any),
    .same_idx(fill_same_idx), .slot(fill_slot), .advance(fill_adv)
  );

  assign fill_we = fill_en & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_we) begin
      valid_q[fill_slot] <= 1'b1;
      if (fill_adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_slot]  <= fill_vpn;
      ppn_q[fill_slot]  <= fill_ppn;
      perm_q[fill_slot] <= perm_t'(fill_perm);
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int ENTRIES = 32,
  parameter int IW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               fill_en,
  input logic               lk_req,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic               lk_fault,
  input logic               fill_adv,
  input logic [ENTRIES-1:0] valid_q,
  input logic [IW-1:0]      ptr_q
);
  // R2: no lookup, no response
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !lk_hit && !lk_miss && !lk_fault);

  // R4: a fault is only raised on a hit
  assert_fault_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  // R6: flush empties the array and resets the pointer
  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0 && ptr_q == '0);

  // R7: flush with refill leaves nothing valid
  assert_flush_beats_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush && fill_en |=> !lk_hit);

  // R5: a refill never shrinks the valid set
  assert_fill_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $countones(valid_q) >= $countones($past(valid_q)));

  // R5: pointer moves only on a replacement
  assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !flush && fill_adv |=> ptr_q != $past(ptr_q));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !(fill_en && fill_adv) |=> $stable(ptr_q));
endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
  .lk_req(lk_req), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
  .fill_adv(fill_adv), .valid_q(valid_q), .ptr_q(ptr_q)
);

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_ofs = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_user = 1'b0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [33:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [21:0] fill_ppn = '0;
  logic [4:0]  fill_perm = '0;

  int n_chk = 0;
  int n_bad = 0;

  xlat_tlb #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_ofs(lk_ofs), .lk_kind(lk_kind), .lk_user(lk_user), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [21:0] p,
                      input logic [4:0] pm, input bit fl);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm; flush = fl;
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] o,
                      input logic [1:0] k, input bit u);
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_ofs = o; lk_kind = k; lk_user = u;
    #1;
  endtask

  // expect a clean hit with given ppn and no fault
  task automatic exp_hit(input logic [19:0] v, input logic [21:0] p, input string req);
    look(v, 12'hA5C, 2'b00, 1'b0);
    chk(lk_hit && !lk_miss && !lk_fault, req, {lk_hit, lk_miss, lk_fault}, 3'b100);
    chk(lk_paddr == {p, 12'hA5C}, req, lk_paddr, {p, 12'hA5C});
  endtask

  task automatic exp_miss(input logic [19:0] v, input string req);
    look(v, 12'h001, 2'b00, 1'b0);
    chk(!lk_hit && lk_miss && !lk_fault && lk_paddr == 0, req,
        {lk_hit, lk_miss, lk_fault, lk_paddr}, 37'h0_8_0000_0000);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [19:0] vx;
    logic [21:0] px;
    vx = 20'h12345;
    px = 22'h2ABCD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8, R2: empty after reset
    exp_miss(vx, "R8");
    @(negedge clk); lk_req = 1'b0; #1;
    chk(!lk_hit && !lk_miss && !lk_fault && lk_paddr == 0, "R2",
        {lk_hit, lk_miss, lk_fault}, 0);

    // R1, R3, R4: every permission code, kind and mode on one page
    for (int p = 0; p < 32; p++) begin
      fill(vx, px + 22'(p), 5'(p), 1'b0);
      for (int k = 0; k < 4; k++) begin
        for (int u = 0; u < 2; u++) begin
          bit r, w, x, uu, d, dirty_miss, allow;
          r = p[0]; w = p[1]; x = p[2]; uu = p[3]; d = p[4];
          dirty_miss = (k == 1) && !d;
          allow = ((k == 0) && r || (k == 1) && w || (k == 2) && x) && (u == int'(uu));
          look(vx, 12'(p * 97 + k), 2'(k), u[0]);
          if (dirty_miss) begin
            chk(!lk_hit && lk_miss && !lk_fault, "R3", {lk_hit, lk_miss, lk_fault}, 3'b010);
          end else begin
            chk(lk_hit && !lk_miss, "R1", {lk_hit, lk_miss}, 2'b10);
            chk(lk_paddr == {px + 22'(p), 12'(p * 97 + k)}, "R1", lk_paddr,
                {px + 22'(p), 12'(p * 97 + k)});
            chk(lk_fault == !allow, "R4", lk_fault, !allow);
          end
        end
      end
    end

    // R5: rewrites stayed in one slot; fill three more then evict slot 0
    fill(20'h00001, 22'h101, 5'b10111, 1'b0);
    fill(20'h00002, 22'h102, 5'b10111, 1'b0);
    fill(20'h00003, 22'h103, 5'b10111, 1'b0);
    fill(20'h00004, 22'h104, 5'b10111, 1'b0);
    exp_miss(vx, "R5");
    exp_hit(20'h00001, 22'h101, "R5");
    exp_hit(20'h00004, 22'h104, "R5");
    fill(20'h00005, 22'h105, 5'b10111, 1'b0);
    exp_miss(20'h00001, "R5");
    exp_hit(20'h00002, 22'h102, "R5");

    // R6: flush clears all
    do_flush();
    exp_miss(20'h00002, "R6");
    exp_miss(20'h00005, "R6");

    // R6, R5: pointer back at 0 after flush, then wraps
    for (int i = 0; i < 4; i++) fill(20'h00100 + 20'(i), 22'h200 + 22'(i), 5'b10111, 1'b0);
    for (int i = 0; i < 4; i++) exp_hit(20'h00100 + 20'(i), 22'h200 + 22'(i), "R5");
    fill(20'h00104, 22'h204, 5'b10111, 1'b0);
    exp_miss(20'h00100, "R6");
    exp_hit(20'h00101, 22'h201, "R6");
    for (int i = 5; i < 8; i++) fill(20'h00100 + 20'(i), 22'h200 + 22'(i), 5'b10111, 1'b0);
    fill(20'h00108, 22'h208, 5'b10111, 1'b0);
    exp_miss(20'h00104, "R5");
    for (int i = 5; i < 9; i++) exp_hit(20'h00100 + 20'(i), 22'h200 + 22'(i), "R5");

    // R7: flush and refill together
    fill(20'h0BEEF, 22'h3FF, 5'b10111, 1'b1);
    exp_miss(20'h0BEEF, "R7");
    exp_miss(20'h00105, "R7");

    @(negedge clk); lk_req = 1'b0;
    finish_up();
  end
endmodule